// File: doc/BRIEF.md
# Indexed Nested Interrupt Controller

This block collects up to 128 interrupt inputs and presents one active-low request line, `irq_n`, to a processor. Software sets up each source through a narrow window. It first writes a source number into a select register. Every later per-source access then applies only to that source: mode, vector, enable, disable, clear-pending and force-pending. No wide per-source bitmap registers exist.

Each source has a priority (0 lowest, 7 highest) and one of four trigger types. The handler reads the vector register to learn which source to serve. That read pushes the winning priority onto an eight-entry nesting stack. Only sources with a strictly higher priority can then raise the line again. An end-of-interrupt write pops the stack. If the vector register is read when no source qualifies, it returns a programmable spurious value.

Top module: `idx_intc`

## Requirements
- R1: The select register at offset 0x00 holds a 7-bit source number in bits [6:0]. Higher bits are dropped on write. It reads back zero-extended.
- R2: A write of any value to 0x40 enables the selected source, and a write to 0x44 disables it. Bit 0 of the mask-status register at 0x30 reads the enable of the selected source.
- R3: Offsets 0x04 (mode) and 0x08 (32-bit vector) read and write the selected source only. The mode layout is priority in bits [2:0] and trigger in bits [6:5]. Trigger codes are 00 level-low, 01 falling edge, 10 level-high and 11 rising edge. All other mode bits read zero.
- R4: A level source counts as pending while its input, after a two-flop synchronizer, sits at its active level.
- R5: An edge source latches a pending bit on the selected transition, and the bit stays after the input returns. A write to 0x48 clears the selected source's pending bit. A write to 0x4C forces it pending.
- R6: `irq_n` goes low one clock after some enabled pending source exists whose priority is strictly above the top of the nesting stack, or after any such source exists while the stack is empty. Among the highest-priority sources, the lowest source number wins.
- R7: A read of 0x10 returns the winner's vector and pushes its priority. The read also clears the winner's latched pending bit. After the read, 0x18 returns the winner's source number.
- R8: A write to 0x38 pops one stack level. A write to 0x38 with the stack empty has no effect. The stack holds eight levels, so eight such writes empty it.
- R9: When no source qualifies, a read of 0x10 returns the value last written to 0x3C and pushes nothing. After that read, 0x18 returns zero.
- R10: Bit 1 of 0x34 reads 1 while `irq_n` is low and 0 while it is high.
- R11: After reset, all sources are disabled with no latched pending bit, the stack is empty, the spurious value is zero and `irq_n` is high. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 128 | Raw interrupt inputs, one bit per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read side effects apply at the clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
On every cycle, the assertions check the stack: its depth stays in range and it grows by one on each granted vector read. An end-of-interrupt write shrinks it by one, or leaves an empty stack alone. A spurious read leaves the depth alone. The request line must also be high one cycle after no source is pending. Only the bench scenarios can show the rest. That covers the vector and source number a read returns, including ties broken by lowest source number. It also covers the strict-priority nesting rule across eight levels and the behaviour of each trigger type. The index-select semantics are exercised too: a command touches only the selected source.

// File: rtl/ixc_pkg.sv
`timescale 1ns/1ps
package ixc_pkg;
  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_SEL  = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_VEC  = 8'h08;
  localparam logic [7:0] OFS_IVEC = 8'h10;
  localparam logic [7:0] OFS_CUR  = 8'h18;
  localparam logic [7:0] OFS_MSK  = 8'h30;
  localparam logic [7:0] OFS_STAT = 8'h34;
  localparam logic [7:0] OFS_EOI  = 8'h38;
  localparam logic [7:0] OFS_SPUR = 8'h3C;
  localparam logic [7:0] OFS_ENA  = 8'h40;
  localparam logic [7:0] OFS_DIS  = 8'h44;
  localparam logic [7:0] OFS_CLR  = 8'h48;
  localparam logic [7:0] OFS_SET  = 8'h4C;

  // Trigger encodings held in mode bits [6:5]
  localparam logic [1:0] TRIG_LO   = 2'b00;
  localparam logic [1:0] TRIG_FALL = 2'b01;
  localparam logic [1:0] TRIG_HI   = 2'b10;
  localparam logic [1:0] TRIG_RISE = 2'b11;

  localparam int TRIG_LSB = 5;

  // Transition detector for the edge trigger types
  function automatic logic edge_seen(input logic [1:0] trig, input logic now_v, input logic was_v);
    case (trig)
      TRIG_RISE: return now_v & ~was_v;
      TRIG_FALL: return ~now_v & was_v;
      default:   return 1'b0;
    endcase
  endfunction

  // Active-level test for the level trigger types
  function automatic logic level_on(input logic [1:0] trig, input logic now_v);
    case (trig)
      TRIG_HI: return now_v;
      TRIG_LO: return ~now_v;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ixc_src_slot.sv
`timescale 1ns/1ps
module ixc_src_slot
  import ixc_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_in,
  input  logic              sel_hit,
  input  logic              wr_mode,
  input  logic              wr_vec,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              cmd_clr,
  input  logic              cmd_set,
  input  logic              ack,
  input  logic [DW-1:0]     wdata,
  output logic [PRIO_W-1:0] prio_o,
  output logic [1:0]        trig_o,
  output logic [DW-1:0]     vec_o,
  output logic              en_o,
  output logic              cand_o
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic       latch_q;
  logic       edge_hit;
  logic       lvl_hit;

  assign edge_hit = edge_seen(trig_o, sync_q[1], prev_q);
  assign lvl_hit  = level_on(trig_o, sync_q[1]);
  assign cand_o   = en_o & (latch_q | lvl_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
      en_o    <= 1'b0;
      prio_o  <= '0;
      trig_o  <= TRIG_LO;
      vec_o   <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_in};
      prev_q <= sync_q[1];
      if (sel_hit && cmd_set)                latch_q <= 1'b1;
      else if ((sel_hit && cmd_clr) || ack)  latch_q <= 1'b0;
      else if (edge_hit)                     latch_q <= 1'b1;
      if (sel_hit && cmd_en)       en_o <= 1'b1;
      else if (sel_hit && cmd_dis) en_o <= 1'b0;
      if (sel_hit && wr_mode) begin
        prio_o <= wdata[PRIO_W-1:0];
        trig_o <= wdata[TRIG_LSB+1:TRIG_LSB];
      end
      if (sel_hit && wr_vec) vec_o <= wdata;
    end
  end
endmodule

// File: rtl/ixc_pick.sv
`timescale 1ns/1ps
module ixc_pick #(
  parameter int N  = 128,
  parameter int PW = 3,
  parameter int IW = 7
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 found,
  output logic [IW-1:0]        idx,
  output logic [PW-1:0]        best
);
  // Strict greater-than keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i] > best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/ixc_nest_stack.sv
`timescale 1ns/1ps
module ixc_nest_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic [CW-1:0] cnt,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] tp;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign wp    = cnt[PW-1:0];
  assign tp    = wp - 1'b1;
  assign top   = empty ? '0 : mem[tp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      if (!full) begin
        mem[wp] <= din;
        cnt     <= cnt + 1'b1;
      end
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/idx_intc.sv
`timescale 1ns/1ps
module idx_intc
  import ixc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 3,
  parameter int DEPTH   = 8,
  parameter int AW      = 8,
  parameter int DW      = 32,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq_n
);
  logic [IDX_W-1:0] sel_q;
  logic [IDX_W-1:0] cur_q;
  logic [DW-1:0]    spur_q;

  logic [NUM_SRC-1:0]             cand_v, en_v, ack_v;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;
  logic [NUM_SRC-1:0][1:0]        trig_v;
  logic [NUM_SRC-1:0][DW-1:0]     vec_v;

  logic              win_found;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic [PRIO_W-1:0] stk_top;
  logic [CNT_W-1:0]  stk_cnt;
  logic              stk_empty, stk_full;

  // Named internal events (also observed by the checker)
  logic irq_go, ivec_rd, stk_push, stk_pop, spur_rd, any_cand;
  logic wr_mode, wr_vec, c_en, c_dis, c_clr, c_set;

  function automatic logic outranks(input logic found, input logic [PRIO_W-1:0] p,
                                    input logic empty, input logic [PRIO_W-1:0] t);
    return found && (empty || p > t);
  endfunction

  function automatic logic wr_at(input logic [AW-1:0] ofs);
    return bus_wr && (bus_addr == AW'(ofs));
  endfunction

  assign wr_mode  = wr_at(OFS_MODE);
  assign wr_vec   = wr_at(OFS_VEC);
  assign c_en     = wr_at(OFS_ENA);
  assign c_dis    = wr_at(OFS_DIS);
  assign c_clr    = wr_at(OFS_CLR);
  assign c_set    = wr_at(OFS_SET);
  assign stk_pop  = wr_at(OFS_EOI);
  assign ivec_rd  = bus_rd && (bus_addr == AW'(OFS_IVEC));
  assign irq_go   = outranks(win_found, win_prio, stk_empty, stk_top);
  assign stk_push = ivec_rd && irq_go;
  assign spur_rd  = ivec_rd && !irq_go;
  assign any_cand = |cand_v;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    assign ack_v[g] = stk_push && (win_idx == IDX_W'(g));
    ixc_src_slot #(.PRIO_W(PRIO_W), .DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n), .raw_in(src_in[g]),
      .sel_hit(sel_q == IDX_W'(g)),
      .wr_mode(wr_mode), .wr_vec(wr_vec), .cmd_en(c_en), .cmd_dis(c_dis),
      .cmd_clr(c_clr), .cmd_set(c_set), .ack(ack_v[g]), .wdata(bus_wdata),
      .prio_o(prio_v[g]), .trig_o(trig_v[g]), .vec_o(vec_v[g]),
      .en_o(en_v[g]), .cand_o(cand_v[g])
    );
  end

  ixc_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_pick (
    .cand(cand_v), .prio(prio_v), .found(win_found), .idx(win_idx), .best(win_prio)
  );

  ixc_nest_stack #(.DEPTH(DEPTH), .W(PRIO_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop), .din(win_prio),
    .top(stk_top), .cnt(stk_cnt), .empty(stk_empty), .full(stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      cur_q  <= '0;
      spur_q <= '0;
      irq_n  <= 1'b1;
    end else begin
      irq_n <= ~irq_go;
      if (wr_at(OFS_SEL))  sel_q  <= bus_wdata[IDX_W-1:0];
      if (wr_at(OFS_SPUR)) spur_q <= bus_wdata;
      if (ivec_rd)         cur_q  <= irq_go ? win_idx : '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_SEL):  bus_rdata[IDX_W-1:0] = sel_q;
      AW'(OFS_MODE): begin
        bus_rdata[PRIO_W-1:0]           = prio_v[sel_q];
        bus_rdata[TRIG_LSB+1:TRIG_LSB]  = trig_v[sel_q];
      end
      AW'(OFS_VEC):  bus_rdata = vec_v[sel_q];
      AW'(OFS_IVEC): bus_rdata = irq_go ? vec_v[win_idx] : spur_q;
      AW'(OFS_CUR):  bus_rdata[IDX_W-1:0] = cur_q;
      AW'(OFS_MSK):  bus_rdata[0] = en_v[sel_q];
      AW'(OFS_STAT): bus_rdata[1] = ~irq_n;
      AW'(OFS_SPUR): bus_rdata = spur_q;
      default:       bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ixc_chk.sv
`timescale 1ns/1ps
module ixc_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic          spur_rd,
  input logic          full,
  input logic          any_cand,
  input logic          irq_n,
  input logic [CW-1:0] cnt
);
  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R7
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && !full |=> cnt == $past(cnt) + 1'b1);

  // R8
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && cnt == '0 |=> cnt == '0);

  // R9
  spur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spur_rd && !pop |=> $stable(cnt));

  // R6
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cand |=> irq_n);
endmodule

bind idx_intc ixc_chk #(.DEPTH(DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop), .spur_rd(spur_rd),
  .full(stk_full), .any_cand(any_cand), .irq_n(irq_n), .cnt(stk_cnt)
);

// File: tb/idx_intc_test.sv
`timescale 1ns/1ps
module idx_intc_test;
  localparam int N = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_in = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench-side model of configuration
  bit        m_en   [N];
  bit [2:0]  m_prio [N];
  bit [1:0]  m_trig [N];
  bit [31:0] m_vec  [N];
  bit [31:0] m_spur;

  always #4 clk = ~clk;

  idx_intc uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int s, input bit [1:0] trig, input bit [2:0] prio, input bit [31:0] vec);
    wr(8'h00, 32'(s));
    wr(8'h04, {25'b0, trig, 2'b00, prio});
    wr(8'h08, vec);
    m_trig[s] = trig; m_prio[s] = prio; m_vec[s] = vec;
  endtask

  task automatic enable(input int s, input bit on);
    wr(8'h00, 32'(s));
    wr(on ? 8'h40 : 8'h44, 32'hFFFF_FFFF);
    m_en[s] = on;
  endtask

  // expected arbitration over level sources with an empty stack
  function automatic bit exp_pick(output int idx);
    bit f = 0;
    idx = 0;
    for (int i = 0; i < N; i++) begin
      bit act = (m_trig[i] == 2'b10) ? src_in[i] : ((m_trig[i] == 2'b00) ? !src_in[i] : 1'b0);
      if (m_en[i] && act && (!f || m_prio[i] > m_prio[idx])) begin
        f = 1; idx = i;
      end
    end
    return f;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w;
    void'($urandom(32'h0001_D5A3));
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = 0;
    end
    m_spur = 0;
    src_in = '1;          // keep level-low defaults idle
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R11 reset state
    check("R11 irq_n after reset", 32'(irq_n), 32'd1);
    rd(8'h30, d); check("R11 mask after reset", d, 32'd0);
    rd(8'h3C, d); check("R11 spurious after reset", d, 32'd0);
    rd(8'h10, d); check("R11 vector read after reset", d, 32'd0);
    rd(8'h60, d); check("R11 unmapped offset", d, 32'd0);

    // R1 select field width
    wr(8'h00, 32'h0000_0185);
    rd(8'h00, d); check("R1 select readback", d, 32'h05);

    // R3 mode/vector per selected source
    setup(5, 2'b11, 3'd5, 32'h0000_ABCD);
    setup(6, 2'b10, 3'd1, 32'h1111_2222);
    wr(8'h00, 32'd5);
    rd(8'h04, d); check("R3 mode readback src5", d, 32'h65);
    rd(8'h08, d); check("R3 vector readback src5", d, 32'h0000_ABCD);
    wr(8'h00, 32'd6);
    wr(8'h04, 32'hFFFF_FF4A);
    rd(8'h04, d); check("R3 unused mode bits zero", d, 32'h42);
    wr(8'h04, 32'h0000_0041); m_prio[6] = 1;

    // R2 enable/disable acts on selected source only
    enable(5, 1);
    rd(8'h30, d); check("R2 enabled mask", d, 32'd1);
    wr(8'h00, 32'd6);
    rd(8'h30, d); check("R2 other source untouched", d, 32'd0);
    enable(5, 0);
    rd(8'h30, d); check("R2 disabled mask", d, 32'd0);
    enable(5, 1);

    // R5 rising edge latch, clear and set commands
    src_in[5] = 1'b0; idle(5);
    src_in[5] = 1'b1; idle(5);
    check("R5 rising edge raises line", 32'(irq_n), 32'd0);
    rd(8'h34, d); check("R10 status while active", d, 32'd2);
    src_in[5] = 1'b0; idle(5);
    check("R5 edge latched after input drop", 32'(irq_n), 32'd0);
    wr(8'h00, 32'd5); wr(8'h48, 32'd0); idle(2);
    check("R5 clear command drops line", 32'(irq_n), 32'd1);
    rd(8'h34, d); check("R10 status while idle", d, 32'd0);
    wr(8'h4C, 32'd0); idle(2);
    check("R5 set command raises line", 32'(irq_n), 32'd0);
    rd(8'h10, d); check("R7 vector of forced source", d, 32'h0000_ABCD);
    rd(8'h18, d); check("R7 current source number", d, 32'd5);
    idle(1);
    check("R7 read clears latched edge", 32'(irq_n), 32'd1);
    wr(8'h38, 32'd0);
    idle(2);
    check("R8 end of interrupt, nothing pending", 32'(irq_n), 32'd1);
    enable(5, 0);

    // R5 falling edge
    setup(13, 2'b01, 3'd2, 32'h0000_0D0D);
    enable(13, 1);
    src_in[13] = 1'b0; idle(5);
    src_in[13] = 1'b1; idle(5);
    check("R5 falling edge latched", 32'(irq_n), 32'd0);
    rd(8'h10, d); check("R5 falling vector", d, 32'h0000_0D0D);
    wr(8'h38, 32'd0);
    enable(13, 0);

    // R4 level-low follows input
    setup(12, 2'b00, 3'd3, 32'h0000_0C0C);
    enable(12, 1); idle(5);
    check("R4 level-low inactive when input high", 32'(irq_n), 32'd1);
    src_in[12] = 1'b0; idle(5);
    check("R4 level-low active when input low", 32'(irq_n), 32'd0);
    src_in[12] = 1'b1; idle(5);
    check("R4 level-low follows input back", 32'(irq_n), 32'd1);
    enable(12, 0);
    src_in = '0;
    for (int i = 0; i < N; i++) if (m_trig[i] == 2'b00) m_trig[i] = 2'b11;

    // R6 nesting and tie break
    setup(10, 2'b10, 3'd2, 32'h100); enable(10, 1);
    setup(20, 2'b10, 3'd6, 32'h200); enable(20, 1);
    setup(21, 2'b10, 3'd6, 32'h201); enable(21, 1);
    src_in[10] = 1'b1; idle(5);
    rd(8'h10, d); check("R7 low-priority vector", d, 32'h100);
    idle(2); check("R6 same level blocked after read", 32'(irq_n), 32'd1);
    src_in[21] = 1'b1; src_in[20] = 1'b1; idle(5);
    check("R6 higher priority preempts", 32'(irq_n), 32'd0);
    rd(8'h10, d); check("R6 tie goes to lower number", d, 32'h200);
    rd(8'h18, d); check("R7 nested source number", d, 32'd20);
    idle(1); check("R6 equal priority cannot nest", 32'(irq_n), 32'd1);
    src_in[20] = 1'b0; idle(5);
    wr(8'h38, 32'd0); idle(2);
    check("R6 pop re-exposes equal source", 32'(irq_n), 32'd0);
    rd(8'h10, d); check("R6 remaining tie source", d, 32'h201);
    src_in[21] = 1'b0; src_in[10] = 1'b0; idle(5);
    wr(8'h38, 32'd0); wr(8'h38, 32'd0);
    enable(10, 0); enable(20, 0); enable(21, 0);

    // R9 spurious
    wr(8'h3C, 32'h5A5A_0001); m_spur = 32'h5A5A_0001;
    rd(8'h10, d); check("R9 spurious value", d, 32'h5A5A_0001);
    rd(8'h18, d); check("R9 source number zero", d, 32'd0);

    // R8 eight-level unwind
    for (int i = 0; i < 8; i++) begin
      setup(40 + i, 2'b10, 3'(i), 32'h400 + 32'(i)); enable(40 + i, 1);
    end
    for (int i = 0; i < 8; i++) begin
      src_in[40 + i] = 1'b1; idle(5);
      check("R6 nest level raises line", 32'(irq_n), 32'd0);
      rd(8'h10, d); check("R8 nest level vector", d, 32'h400 + 32'(i));
    end
    for (int i = 0; i < 8; i++) src_in[40 + i] = 1'b0;
    idle(5);
    for (int i = 0; i < 7; i++) wr(8'h38, 32'd0);
    src_in[40] = 1'b1; idle(5);
    check("R8 lowest level still stacked", 32'(irq_n), 32'd1);
    wr(8'h38, 32'd0); idle(2);
    check("R8 eighth pop empties stack", 32'(irq_n), 32'd0);
    rd(8'h10, d);
    src_in[40] = 1'b0; idle(5);
    wr(8'h38, 32'd0); wr(8'h38, 32'd0);
    src_in[40] = 1'b1; idle(5);
    check("R8 pop on empty ignored", 32'(irq_n), 32'd0);
    src_in[40] = 1'b0; idle(5);
    for (int i = 0; i < 8; i++) enable(40 + i, 0);

    // random level-high scenarios (R6, R7, R9)
    for (int it = 0; it < 30; it++) begin
      int picked [4];
      for (int k = 0; k < 4; k++) begin
        int s = 60 + int'($urandom % 60);
        picked[k] = s;
        setup(s, 2'b10, 3'($urandom % 8), $urandom);
        enable(s, 1);
        src_in[s] = 1'($urandom % 2);
      end
      idle(5);
      if (exp_pick(w)) begin
        check("R6 random line active", 32'(irq_n), 32'd0);
        rd(8'h10, d); check("R7 random winner vector", d, m_vec[w]);
        rd(8'h18, d); check("R7 random winner number", d, 32'(w));
        check("R6 random line released", 32'(irq_n), 32'd1);
      end else begin
        check("R9 random line idle", 32'(irq_n), 32'd1);
        rd(8'h10, d); check("R9 random spurious", d, m_spur);
      end
      wr(8'h38, 32'd0);
      for (int k = 0; k < 4; k++) begin
        enable(picked[k], 0);
        src_in[picked[k]] = 1'b0;
      end
      idle(4);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule